// File: doc/BRIEF.md
# Debug Watchpoint and Breakpoint Unit

This block sits beside an 8-bit CPU core and watches its instruction fetch bus and its three data-access buses: internal data memory, special function registers and external data memory. It holds one program-counter breakpoint and one watchpoint per data space. When a programmed condition matches, it sets a per-source hit flag and raises a halt request. The halt/step sequencer uses that request to stop the core. A fetch breakpoint is flagged at fetch time, so the sequencer can stop the core before that instruction executes.

Each watchpoint has three settings. Its access type selects reads, writes, either or neither. Its address is compared at the full width of its space: 8 bits for internal data and special function registers, 24 bits for external data. An optional data qualifier also requires the transferred byte to equal a programmed pattern. Accesses that the debugger makes itself never trigger a match. Configuration and flag clearing use a byte-wide register-write port. Two status outputs report whether a debugger access is in progress and whether the core is executing.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, hit_o is 0000, halt_req_o is 0, the breakpoint is disabled and every watchpoint has access type 00 (off).
- R2: When the breakpoint is enabled (bit 0 of register 0x01) and fetch_valid_i is high with fetch_addr_i equal to the programmed value (low byte in 0x02, high byte in 0x03), hit_o[0] is set at the next clock edge. A disabled breakpoint never sets it.
- R3: A watchpoint's control register has the access type in bits 1:0: 00 off, 01 reads only, 10 writes only, 11 either. An access sets a hit only if its direction is selected.
- R4: When bit 2 of a watchpoint's control register is set, a hit also requires the access data to equal that watchpoint's pattern register. When it is clear, the data is ignored.
- R5: Addresses are compared at full width. This is 8 bits for internal data and special function registers and 24 bits for external data, so a difference in any single bit, including bit 23, gives no hit.
- R6: Hit flags are sticky. A flag stays set until a write to register 0x00 has a 1 in that flag's bit. hit_o bit 0 is the breakpoint, bit 1 is internal data, bit 2 is special function registers and bit 3 is external data.
- R7: If a match and a clear of the same flag occur in the same cycle, the flag ends up set.
- R8: While dbg_access_i is high, no fetch or data access sets any flag.
- R9: halt_req_o is high exactly when at least one hit flag is set, and it changes in the same cycle as the flags.
- R10: debug_busy_o follows dbg_access_i. code_run_o is insn_active_i while no halt is requested, and 0 while one is requested.
- R11: The register map is as follows. Internal data memory uses control 0x04, address 0x05 and pattern 0x06. Special function registers use control 0x08, address 0x09 and pattern 0x0A. External data memory uses control 0x0C, pattern 0x0E, and address bytes 0x0D (bits 7:0), 0x0F (bits 15:8) and 0x10 (bits 23:16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register index |
| cfg_wdata | input | 8 | Register write data |
| fetch_valid_i | input | 1 | Instruction fetch in this cycle |
| fetch_addr_i | input | 16 | Fetch address |
| iram_valid_i | input | 1 | Internal data access in this cycle |
| iram_write_i | input | 1 | Internal data access is a write |
| iram_addr_i | input | 8 | Internal data address |
| iram_data_i | input | 8 | Internal data byte transferred |
| sfr_valid_i | input | 1 | Special function register access in this cycle |
| sfr_write_i | input | 1 | Special function register access is a write |
| sfr_addr_i | input | 8 | Special function register address |
| sfr_data_i | input | 8 | Special function register byte transferred |
| xram_valid_i | input | 1 | External data access in this cycle |
| xram_write_i | input | 1 | External data access is a write |
| xram_addr_i | input | 24 | External data address |
| xram_data_i | input | 8 | External data byte transferred |
| dbg_access_i | input | 1 | Current access is made by the debugger |
| insn_active_i | input | 1 | Core is executing an instruction |
| hit_o | output | 4 | Sticky hit flags |
| halt_req_o | output | 1 | Halt request |
| code_run_o | output | 1 | Core running and not held by a request |
| debug_busy_o | output | 1 | Debugger access in progress |

## Verification
The assertions assume that when no bus carries a valid access, nothing can raise a flag. They also assume that a clear-all write made on a quiet cycle leaves every flag low. The bench therefore keeps every valid strobe low whenever it writes configuration or clears flags, except in the single cycle that deliberately overlaps a clear with a match. Stimulus is applied one access at a time and held for exactly one clock, so each flag change can be traced to one bus event.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
    localparam int DW      = 8;
    localparam int PCW     = 16;
    localparam int XAW     = 24;
    localparam int CFG_AW  = 5;
    localparam int NWP     = 3;
    localparam int NSRC    = NWP + 1;

    typedef enum logic [1:0] {
        ACC_OFF   = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_ANY   = 2'b11
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic             den;
        logic [XAW-1:0]   addr;
        logic [DW-1:0]    pat;
    } wp_cfg_t;

    typedef struct packed {
        logic                pc_en;
        logic [PCW-1:0]      pc_val;
        wp_cfg_t [NWP-1:0]   wp;
        logic [NSRC-1:0]     hit;
        logic                halt;
    } state_t;
endpackage

// File: rtl/dbg_pc_match.sv
module dbg_pc_match
    import dbg_watch_pkg::*;
(
    input  logic           en,
    input  logic [PCW-1:0] target,
    input  logic           fetch_valid,
    input  logic [PCW-1:0] fetch_addr,
    input  logic           ignore,
    output logic           match
);
    always_comb begin
        match = en && fetch_valid && !ignore && (fetch_addr == target);
    end
endmodule

// File: rtl/dbg_wp_match.sv
module dbg_wp_match
    import dbg_watch_pkg::*;
(
    input  wp_cfg_t         cfg,
    input  logic            valid,
    input  logic            write,
    input  logic [XAW-1:0]  addr,
    input  logic [DW-1:0]   data,
    input  logic            ignore,
    output logic            match
);
    logic dir_ok;

    always_comb begin
        unique case (cfg.kind)
            ACC_READ:  dir_ok = !write;
            ACC_WRITE: dir_ok = write;
            ACC_ANY:   dir_ok = 1'b1;
            default:   dir_ok = 1'b0;
        endcase
        match = valid && !ignore && dir_ok && (addr == cfg.addr)
                && (!cfg.den || (data == cfg.pat));
    end
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
    import dbg_watch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              fetch_valid_i,
    input  logic [PCW-1:0]    fetch_addr_i,
    input  logic              iram_valid_i,
    input  logic              iram_write_i,
    input  logic [7:0]        iram_addr_i,
    input  logic [DW-1:0]     iram_data_i,
    input  logic              sfr_valid_i,
    input  logic              sfr_write_i,
    input  logic [7:0]        sfr_addr_i,
    input  logic [DW-1:0]     sfr_data_i,
    input  logic              xram_valid_i,
    input  logic              xram_write_i,
    input  logic [XAW-1:0]    xram_addr_i,
    input  logic [DW-1:0]     xram_data_i,
    input  logic              dbg_access_i,
    input  logic              insn_active_i,
    output logic [NSRC-1:0]   hit_o,
    output logic              halt_req_o,
    output logic              code_run_o,
    output logic              debug_busy_o
);
    localparam int REG_CLEAR  = 0;
    localparam int REG_PC_EN  = 1;
    localparam int REG_PC_LO  = 2;
    localparam int REG_PC_HI  = 3;
    localparam int WP_BASE    = 4;
    localparam int WP_STRIDE  = 4;
    localparam int REG_XA_MID = WP_BASE + WP_STRIDE * (NWP - 1) + 3;
    localparam int REG_XA_HI  = REG_XA_MID + 1;

    state_t state_d, state_q;

    logic [NWP-1:0]           acc_valid;
    logic [NWP-1:0]           acc_write;
    logic [NWP-1:0][XAW-1:0]  acc_addr;
    logic [NWP-1:0][DW-1:0]   acc_data;
    logic [NWP-1:0]           wp_match;
    logic                     pc_match;

    always_comb begin
        acc_valid = {xram_valid_i, sfr_valid_i, iram_valid_i};
        acc_write = {xram_write_i, sfr_write_i, iram_write_i};
        acc_addr  = {xram_addr_i, {(XAW-8){1'b0}}, sfr_addr_i,
                     {(XAW-8){1'b0}}, iram_addr_i};
        acc_data  = {xram_data_i, sfr_data_i, iram_data_i};
    end

    dbg_pc_match u_pc (
        .en          (state_q.pc_en),
        .target      (state_q.pc_val),
        .fetch_valid (fetch_valid_i),
        .fetch_addr  (fetch_addr_i),
        .ignore      (dbg_access_i),
        .match       (pc_match)
    );

    for (genvar g = 0; g < NWP; g++) begin : g_wp
        dbg_wp_match u_wp (
            .cfg    (state_q.wp[g]),
            .valid  (acc_valid[g]),
            .write  (acc_write[g]),
            .addr   (acc_addr[g]),
            .data   (acc_data[g]),
            .ignore (dbg_access_i),
            .match  (wp_match[g])
        );
    end

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            if (cfg_addr == CFG_AW'(REG_CLEAR))
                state_d.hit = state_q.hit & ~cfg_wdata[NSRC-1:0];
            if (cfg_addr == CFG_AW'(REG_PC_EN))
                state_d.pc_en = cfg_wdata[0];
            if (cfg_addr == CFG_AW'(REG_PC_LO))
                state_d.pc_val[7:0] = cfg_wdata;
            if (cfg_addr == CFG_AW'(REG_PC_HI))
                state_d.pc_val[PCW-1:8] = cfg_wdata[PCW-9:0];
            for (int i = 0; i < NWP; i++) begin
                if (cfg_addr == CFG_AW'(WP_BASE + WP_STRIDE * i)) begin
                    state_d.wp[i].kind = acc_kind_e'(cfg_wdata[1:0]);
                    state_d.wp[i].den  = cfg_wdata[2];
                end
                if (cfg_addr == CFG_AW'(WP_BASE + WP_STRIDE * i + 1))
                    state_d.wp[i].addr[7:0] = cfg_wdata;
                if (cfg_addr == CFG_AW'(WP_BASE + WP_STRIDE * i + 2))
                    state_d.wp[i].pat = cfg_wdata[DW-1:0];
            end
            if (cfg_addr == CFG_AW'(REG_XA_MID))
                state_d.wp[NWP-1].addr[15:8] = cfg_wdata;
            if (cfg_addr == CFG_AW'(REG_XA_HI))
                state_d.wp[NWP-1].addr[23:16] = cfg_wdata;
        end
        state_d.hit  = state_d.hit | {wp_match, pc_match};
        state_d.halt = |state_d.hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        hit_o        = state_q.hit;
        halt_req_o   = state_q.halt;
        code_run_o   = insn_active_i && !state_q.halt;
        debug_busy_o = dbg_access_i;
    end
endmodule

// File: rtl/dbg_watch_unit_chk.sv
module dbg_watch_unit_chk
    import dbg_watch_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic              fetch_valid_i,
    input logic              iram_valid_i,
    input logic              sfr_valid_i,
    input logic              xram_valid_i,
    input logic              dbg_access_i,
    input logic              insn_active_i,
    input logic [NSRC-1:0]   hit_o,
    input logic              halt_req_o,
    input logic              code_run_o
);
    logic quiet;
    logic clr_all;

    always_comb begin
        quiet   = !fetch_valid_i && !iram_valid_i && !sfr_valid_i && !xram_valid_i;
        clr_all = cfg_we && (cfg_addr == '0) && (cfg_wdata[NSRC-1:0] == '1);
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_sticky
        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_o[g] && !(cfg_we && (cfg_addr == '0) && cfg_wdata[g])) |=> hit_o[g]);
    end

    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && hit_o == '0) |=> (hit_o == '0));

    p_dbg_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_access_i && hit_o == '0) |=> (hit_o == '0));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && clr_all) |=> (hit_o == '0));

    p_halt_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req_o) |-> ($past(hit_o) == '0 && hit_o != '0));

    p_run_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req_o || !insn_active_i) |-> !code_run_o);
endmodule

bind dbg_watch_unit dbg_watch_unit_chk u_chk (.*);

// File: tb/dbg_watch_unit_bench.sv
`timescale 1ns/1ps
module dbg_watch_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        fetch_valid_i = 1'b0;
    logic [15:0] fetch_addr_i = '0;
    logic        iram_valid_i = 1'b0, iram_write_i = 1'b0;
    logic [7:0]  iram_addr_i = '0, iram_data_i = '0;
    logic        sfr_valid_i = 1'b0, sfr_write_i = 1'b0;
    logic [7:0]  sfr_addr_i = '0, sfr_data_i = '0;
    logic        xram_valid_i = 1'b0, xram_write_i = 1'b0;
    logic [23:0] xram_addr_i = '0;
    logic [7:0]  xram_data_i = '0;
    logic        dbg_access_i = 1'b0;
    logic        insn_active_i = 1'b0;
    logic [3:0]  hit_o;
    logic        halt_req_o, code_run_o, debug_busy_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dbg_watch_unit u_dbg_watch_unit (.*);

    localparam int NV = 12;
    localparam logic [39:0] VEC [NV] = '{
        {3'd1, 1'b0, 24'h000030, 8'h00, 4'b0010},
        {3'd1, 1'b1, 24'h000030, 8'h00, 4'b0000},
        {3'd1, 1'b0, 24'h000031, 8'h00, 4'b0000},
        {3'd2, 1'b1, 24'h000090, 8'hA5, 4'b0100},
        {3'd2, 1'b1, 24'h000090, 8'hA4, 4'b0000},
        {3'd2, 1'b0, 24'h000090, 8'hA5, 4'b0000},
        {3'd3, 1'b0, 24'h123456, 8'h00, 4'b1000},
        {3'd3, 1'b1, 24'h123456, 8'h77, 4'b1000},
        {3'd3, 1'b0, 24'h923456, 8'h00, 4'b0000},
        {3'd0, 1'b0, 24'h001234, 8'h00, 4'b0001},
        {3'd0, 1'b0, 24'h001235, 8'h00, 4'b0000},
        {3'd3, 1'b1, 24'h123457, 8'h00, 4'b0000}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [2:0] kind, input logic w,
                         input logic [23:0] a, input logic [7:0] d);
        case (kind)
            3'd0: begin fetch_valid_i = 1'b1; fetch_addr_i = a[15:0]; end
            3'd1: begin iram_valid_i = 1'b1; iram_write_i = w; iram_addr_i = a[7:0]; iram_data_i = d; end
            3'd2: begin sfr_valid_i = 1'b1; sfr_write_i = w; sfr_addr_i = a[7:0]; sfr_data_i = d; end
            default: begin xram_valid_i = 1'b1; xram_write_i = w; xram_addr_i = a; xram_data_i = d; end
        endcase
    endtask

    task automatic idle_bus();
        fetch_valid_i = 1'b0; iram_valid_i = 1'b0;
        sfr_valid_i = 1'b0; xram_valid_i = 1'b0;
    endtask

    task automatic acc(input logic [2:0] kind, input logic w,
                       input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        drive(kind, w, a, d);
        @(negedge clk);
        idle_bus();
    endtask

    initial begin
        #(200000 * 4);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 hit after reset", {4'b0, hit_o}, 8'h00);
        check("R1 halt after reset", {7'b0, halt_req_o}, 8'h00);
        rst_n = 1'b1;
        acc(3'd1, 1'b0, 24'h000000, 8'h00);
        acc(3'd0, 1'b0, 24'h000000, 8'h00);
        check("R1 disabled after reset", {4'b0, hit_o}, 8'h00);

        wr(5'h01, 8'h01); wr(5'h02, 8'h34); wr(5'h03, 8'h12);
        wr(5'h04, 8'h01); wr(5'h05, 8'h30);
        wr(5'h08, 8'h06); wr(5'h09, 8'h90); wr(5'h0A, 8'hA5);
        wr(5'h0C, 8'h03); wr(5'h0D, 8'h56); wr(5'h0F, 8'h34); wr(5'h10, 8'h12);

        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            acc(v[39:37], v[36], v[35:12], v[11:4]);
            check($sformatf("R2 R3 R4 R5 R11 vector %0d", i), {4'b0, hit_o}, {4'b0, v[3:0]});
            wr(5'h00, 8'h0F);
        end

        wr(5'h04, 8'h05); wr(5'h06, 8'h5A);
        acc(3'd1, 1'b0, 24'h000030, 8'h5A);
        check("R4 pattern equal", {4'b0, hit_o}, 8'h02);
        wr(5'h00, 8'h0F);
        acc(3'd1, 1'b0, 24'h000030, 8'h5B);
        check("R4 pattern differs", {4'b0, hit_o}, 8'h00);

        wr(5'h04, 8'h00);
        acc(3'd1, 1'b0, 24'h000030, 8'h00);
        check("R3 type off", {4'b0, hit_o}, 8'h00);
        wr(5'h04, 8'h03);
        acc(3'd1, 1'b1, 24'h000030, 8'h00);
        check("R3 type either write", {4'b0, hit_o}, 8'h02);
        wr(5'h00, 8'h0F);

        wr(5'h01, 8'h00);
        acc(3'd0, 1'b0, 24'h001234, 8'h00);
        check("R2 breakpoint disabled", {4'b0, hit_o}, 8'h00);

        insn_active_i = 1'b1;
        #1;
        check("R10 run without halt", {7'b0, code_run_o}, 8'h01);
        acc(3'd3, 1'b0, 24'h123456, 8'h00);
        check("R9 halt with hit", {7'b0, halt_req_o}, 8'h01);
        check("R10 run gated by halt", {7'b0, code_run_o}, 8'h00);
        repeat (5) @(negedge clk);
        check("R6 sticky after idle", {4'b0, hit_o}, 8'h08);
        wr(5'h00, 8'h02);
        check("R6 clear other bit keeps flag", {4'b0, hit_o}, 8'h08);
        wr(5'h00, 8'h08);
        check("R6 clear own bit", {4'b0, hit_o}, 8'h00);
        check("R9 halt drops", {7'b0, halt_req_o}, 8'h00);
        insn_active_i = 1'b0;

        @(negedge clk);
        drive(3'd1, 1'b0, 24'h000030, 8'h00);
        cfg_we = 1'b1; cfg_addr = 5'h00; cfg_wdata = 8'h02;
        @(negedge clk);
        idle_bus(); cfg_we = 1'b0;
        check("R7 set wins over clear", {4'b0, hit_o}, 8'h02);
        wr(5'h00, 8'h0F);

        wr(5'h01, 8'h01);
        @(negedge clk);
        dbg_access_i = 1'b1;
        drive(3'd3, 1'b0, 24'h123456, 8'h00);
        drive(3'd1, 1'b0, 24'h000030, 8'h00);
        drive(3'd0, 1'b0, 24'h001234, 8'h00);
        #1;
        check("R10 busy follows debugger", {7'b0, debug_busy_o}, 8'h01);
        @(negedge clk);
        idle_bus(); dbg_access_i = 1'b0;
        check("R8 debugger access ignored", {4'b0, hit_o}, 8'h00);
        #1;
        check("R10 busy released", {7'b0, debug_busy_o}, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule